// File: doc/BRIEF.md
# Four-Channel DMA Engine with Fly-By Transfers and Byte Packing

This block moves data between peripherals and memory on four independent channels. Each channel holds a source address, a destination address, a byte count, a link address and a four-bit mode. The channel is paced by its peripheral through a request/acknowledge pair. One shared sequencer services one channel at a time on a single request/grant memory port. Channel 0 has the highest priority. The bus is released after every transfer unit.

In fly-by mode a transfer unit is a single memory cycle. The peripheral supplies or takes the data directly: write data passes from the peripheral input to the memory port, and read data passes from the memory port to the peripheral output. Neither is held in a register. In two-cycle mode every unit is read into the engine and then written out. Narrow (byte) source units are assembled into a full word, and a full source word is split into bytes for a narrow destination. When a channel's count reaches zero and its link address is nonzero, the engine fetches the next descriptor from memory by itself. When the chain ends, the channel raises a one-cycle completion interrupt on its own line.

Top module: `dma_engine`

## Requirements
- R1: A cycle with `cfg_we` high loads the channel `cfg_ch` with the source, destination, count, link and mode inputs. The channel starts only if the count or the link is nonzero. Mode bits: bit0 fly-by, bit1 fly-by direction (1 = peripheral data written to memory at the destination, 0 = memory read at the source to the peripheral), bit2 source unit is a 4-byte word, bit3 destination unit is a 4-byte word. A clear width bit means a byte.
- R2: Among channels that are ready, the lowest-numbered one is served first. A channel is served for exactly one transfer unit before arbitration runs again. At most one `dack` bit is high in any cycle.
- R3: A fly-by unit is one memory cycle. `dack` is high in the granted cycle itself. `mem_wdata` equals `per_wdata` and `per_rdata` equals `mem_rdata`, with no register on either path. The fly-by unit width follows mode bit3.
- R4: `dack` stays high for exactly one cycle after the completing access and then drops. `dreq` is ignored during that extra cycle. With `dreq` low, a loaded channel issues no memory access.
- R5: With a byte source and a word destination, the engine makes one byte read per byte from consecutive source addresses. Each byte is taken from lane `addr[1:0]`. The engine then makes one word write with byte k of the unit in bits 8k+7..8k.
- R6: With a word source and a byte destination, the engine makes one word read and then one byte write per byte. Each byte is written to lane `dst[1:0]` with a one-hot `mem_be`, taking source byte k in order from bit 0 upward.
- R7: The count falls by the size of each destination unit. A final word holding n < 4 remaining bytes is written with `mem_be` equal to the low n bits set. A write never has `mem_be` equal to zero.
- R8: When the count reaches zero with a nonzero link, the channel reads four words at link+0, +4, +8 and +12 as new source, destination, count and link. It then continues with no configuration input and keeps its mode. These reads give no `dack`.
- R9: When the count reaches zero with a zero link, `irq[ch]` pulses high for one cycle and the channel goes idle.
- R10: While `mem_req` is high and `mem_gnt` is low, the request, address and direction hold steady into the next cycle. No `dack` is given for an ungranted access.
- R11: After synchronous reset all channels are idle, and `mem_req`, `dack` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for one channel |
| cfg_ch | input | 2 | Channel to load |
| cfg_src | input | 32 | Source byte address |
| cfg_dst | input | 32 | Destination byte address |
| cfg_cnt | input | 16 | Byte count |
| cfg_link | input | 32 | Next descriptor address, 0 ends the chain |
| cfg_mode | input | 4 | Mode bits as in R1 |
| dreq | input | 4 | Peripheral requests, one per channel |
| dack | output | 4 | Peripheral acknowledges, one per channel |
| per_wdata | input | 32 | Fly-by data from the peripheral |
| per_rdata | output | 32 | Fly-by data to the peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes in a cycle with request and grant both high |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |
| irq | output | 4 | Per-channel completion pulses |

## Verification
Some properties are checked on every cycle. The assertions cover one acknowledge at a time, the two-cycle acknowledge shape, the stable held request while the grant is low, nonzero write enables, fixed-priority selection, and irq only from an idle channel. Other behaviour shows only in the bench's directed scenarios, through memory contents and logged access orders. These cover byte assembly and splitting with the correct lanes, the partial final word, the fly-by data paths, descriptor fetching across a chain, the interleaving order of two competing channels, and the absence of traffic without `dreq` or with a zero count.

// File: rtl/dma_pkg.sv
package dma_pkg;
    parameter int NCH = 4;
    parameter int AW  = 32;
    parameter int CW  = 16;
    parameter int NB  = 4;
    localparam int DW  = NB * 8;
    localparam int BW  = $clog2(NB);
    localparam int CHW = $clog2(NCH);
    localparam int KW  = (BW > 2) ? BW : 2;

    typedef struct packed {
        logic dst_word;
        logic src_word;
        logic fly_wr;
        logic fly;
    } mode_t;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] link;
        logic [CW-1:0] cnt;
        mode_t         mode;
    } desc_t;

    typedef enum logic [2:0] {S_IDLE, S_FLY, S_RD, S_WR, S_FETCH} seq_st_t;

    function automatic logic [BW:0] unit_len(logic [CW-1:0] cnt, logic wide);
        if (!wide)                return (BW+1)'(1);
        else if (cnt >= CW'(NB))  return (BW+1)'(NB);
        else                      return cnt[BW:0];
    endfunction

    function automatic logic [NB-1:0] low_mask(logic [BW:0] n);
        return NB'((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic [NB-1:0] lane_bit(logic [BW-1:0] lane);
        return NB'(1) << lane;
    endfunction
endpackage

// File: rtl/dma_arb.sv
module dma_arb
    import dma_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           gnt_vld,
    output logic [CHW-1:0] gnt_idx
);
    always_comb begin
        gnt_vld = |req;
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (req[i]) gnt_idx = CHW'(i);
    end

    always_comb begin
        if (gnt_vld) begin
            // R2
            prio_chk: assert ((req & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0 && req[gnt_idx]);
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  desc_t ld_d,
    input  logic  wb,
    input  desc_t wb_d,
    input  logic  fin,
    input  logic  dreq,
    output desc_t d,
    output logic  elig,
    output logic  dack,
    output logic  irq
);
    logic active, hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            d      <= '0;
            active <= 1'b0;
            hold   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq  <= 1'b0;
            hold <= fin;
            if (ld) begin
                d      <= ld_d;
                active <= (ld_d.cnt != '0) || (ld_d.link != '0);
            end else if (wb) begin
                d <= wb_d;
                if (wb_d.cnt == '0 && wb_d.link == '0) begin
                    active <= 1'b0;
                    irq    <= 1'b1;
                end
            end
        end
    end

    // zero count on an active channel means a descriptor fetch is due
    assign elig = active && ((d.cnt == '0) || (dreq && !hold));
    assign dack = fin | hold;

    // R4
    ack_len_chk: assert property (@(posedge clk) disable iff (rst)
        dack && $past(dack) |=> !dack);
    // R9
    irq_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !active || $past(ld));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           sel_vld,
    input  logic [CHW-1:0] sel_idx,
    input  desc_t          sel_d,
    input  logic [DW-1:0]  per_wdata,
    output logic [DW-1:0]  per_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [NB-1:0]  mem_be,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_gnt,
    input  logic [DW-1:0]  mem_rdata,
    output logic           wb,
    output desc_t          wb_d,
    output logic           fin,
    output logic [CHW-1:0] wb_ch
);
    seq_st_t        st;
    desc_t          s, nxt;
    logic [CHW-1:0] ch;
    logic [DW-1:0]  pk_buf;
    logic [KW-1:0]  k;
    logic [BW:0]    n, sz;
    logic           last, go, k_end;

    assign go        = mem_req && mem_gnt;
    assign k_end     = ((BW+1)'(k) == n - (BW+1)'(1));
    assign per_rdata = mem_rdata;

    always_comb begin
        nxt       = s;
        last      = 1'b0;
        sz        = n;
        mem_req   = (st != S_IDLE);
        mem_we    = 1'b0;
        mem_addr  = s.src;
        mem_be    = '1;
        mem_wdata = pk_buf;
        case (st)
            S_FLY: begin
                mem_we    = s.mode.fly_wr;
                mem_addr  = s.mode.fly_wr ? s.dst : s.src;
                mem_be    = s.mode.dst_word ? low_mask(n) : lane_bit(mem_addr[BW-1:0]);
                mem_wdata = per_wdata;
                sz        = s.mode.dst_word ? n : (BW+1)'(1);
                if (s.mode.fly_wr) nxt.dst = s.dst + AW'(sz);
                else               nxt.src = s.src + AW'(sz);
                nxt.cnt   = s.cnt - CW'(sz);
                last      = 1'b1;
            end
            S_RD: begin
                mem_be = s.mode.src_word ? low_mask(n) : lane_bit(s.src[BW-1:0]);
            end
            S_WR: begin
                mem_we   = 1'b1;
                mem_addr = s.dst;
                if (s.mode.dst_word) begin
                    mem_be  = low_mask(n);
                    nxt.dst = s.dst + AW'(n);
                    nxt.cnt = s.cnt - CW'(n);
                    last    = 1'b1;
                end else begin
                    mem_be    = lane_bit(s.dst[BW-1:0]);
                    mem_wdata = {NB{pk_buf[8*k +: 8]}};
                    nxt.dst   = s.dst + AW'(1);
                    nxt.cnt   = s.cnt - CW'(1);
                    last      = k_end;
                end
            end
            S_FETCH: begin
                mem_addr = s.link + AW'(k) * AW'(NB);
                nxt.link = AW'(mem_rdata);
                last     = (k == KW'(3));
            end
            default: ;
        endcase
    end

    assign wb    = go && last;
    assign fin   = wb && (st != S_FETCH);
    assign wb_d  = nxt;
    assign wb_ch = ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ch     <= '0;
            s      <= '0;
            pk_buf <= '0;
            k      <= '0;
            n      <= '0;
        end else begin
            case (st)
                S_IDLE: if (sel_vld) begin
                    ch <= sel_idx;
                    s  <= sel_d;
                    k  <= '0;
                    n  <= sel_d.mode.fly ? unit_len(sel_d.cnt, sel_d.mode.dst_word)
                                         : unit_len(sel_d.cnt, sel_d.mode.src_word | sel_d.mode.dst_word);
                    st <= (sel_d.cnt == '0) ? S_FETCH : (sel_d.mode.fly ? S_FLY : S_RD);
                end
                S_FLY: if (go) st <= S_IDLE;
                S_RD: if (go) begin
                    if (s.mode.src_word) begin
                        pk_buf <= mem_rdata;
                        s.src  <= s.src + AW'(NB);
                        k      <= '0;
                        st     <= S_WR;
                    end else begin
                        pk_buf[8*k +: 8] <= mem_rdata[8*s.src[BW-1:0] +: 8];
                        s.src <= s.src + AW'(1);
                        if (k_end) begin
                            k  <= '0;
                            st <= S_WR;
                        end else begin
                            k <= k + KW'(1);
                        end
                    end
                end
                S_WR: if (go) begin
                    s <= nxt;
                    if (last) st <= S_IDLE;
                    else      k  <= k + KW'(1);
                end
                S_FETCH: if (go) begin
                    case (k)
                        KW'(0):  s.src <= AW'(mem_rdata);
                        KW'(1):  s.dst <= AW'(mem_rdata);
                        KW'(2):  s.cnt <= CW'(mem_rdata);
                        default: ;
                    endcase
                    k <= k + KW'(1);
                    if (last) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R7
    wr_be_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_be != '0);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic [AW-1:0]  cfg_link,
    input  logic [3:0]     cfg_mode,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    input  logic [DW-1:0]  per_wdata,
    output logic [DW-1:0]  per_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [NB-1:0]  mem_be,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_gnt,
    input  logic [DW-1:0]  mem_rdata,
    output logic [NCH-1:0] irq
);
    desc_t          cfg_d, wb_d;
    desc_t          ch_d [NCH];
    logic [NCH-1:0] elig;
    logic           sel_vld, wb, fin;
    logic [CHW-1:0] sel_idx, wb_ch;

    always_comb begin
        cfg_d.src  = cfg_src;
        cfg_d.dst  = cfg_dst;
        cfg_d.cnt  = cfg_cnt;
        cfg_d.link = cfg_link;
        cfg_d.mode = mode_t'(cfg_mode);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan u_ch (
            .clk  (clk),
            .rst  (rst),
            .ld   (cfg_we && cfg_ch == CHW'(g)),
            .ld_d (cfg_d),
            .wb   (wb && wb_ch == CHW'(g)),
            .wb_d (wb_d),
            .fin  (fin && wb_ch == CHW'(g)),
            .dreq (dreq[g]),
            .d    (ch_d[g]),
            .elig (elig[g]),
            .dack (dack[g]),
            .irq  (irq[g])
        );
    end

    dma_arb u_arb (.req(elig), .gnt_vld(sel_vld), .gnt_idx(sel_idx));

    dma_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .sel_vld   (sel_vld),
        .sel_idx   (sel_idx),
        .sel_d     (ch_d[sel_idx]),
        .per_wdata (per_wdata),
        .per_rdata (per_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .wb        (wb),
        .wb_d      (wb_d),
        .fin       (fin),
        .wb_ch     (wb_ch)
    );

    // R2
    one_ack_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dack));
    // R10
    ack_granted_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |-> !fin);
endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_link = '0;
    logic [15:0] cfg_cnt = '0;
    logic [3:0]  cfg_mode = '0;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic [31:0] per_wdata = '0;
    logic [31:0] per_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_gnt = 1'b1;
    logic [31:0] mem_rdata;
    logic [3:0]  irq;

    logic [31:0] mem [64];
    int n_tests = 0, n_fail = 0;
    int acc_n = 0, log_n = 0;
    int log_ch [32];
    int irq_n [4];
    int run [4];
    int max_run = 0;
    logic [31:0] last_prd = '0, last_addr = '0;

    always #5 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_link(cfg_link), .cfg_mode(cfg_mode),
        .dreq(dreq), .dack(dack), .per_wdata(per_wdata), .per_rdata(per_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk)
        if (mem_req && mem_gnt && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

    function automatic int ack_idx(logic [3:0] a);
        for (int i = 0; i < 4; i++) if (a[i]) return i;
        return -1;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_gnt) begin
                acc_n++;
                if (dack != 4'b0) begin
                    if (log_n < 32) log_ch[log_n] = ack_idx(dack);
                    log_n++;
                    last_addr = mem_addr;
                    if (!mem_we) last_prd = per_rdata;
                end
            end
            if (mem_req && !mem_gnt && dack != 4'b0) begin
                n_tests++; n_fail++;
                $display("FAIL R10: dack %b during ungranted access, expected 0000", dack);
            end
            for (int c = 0; c < 4; c++) begin
                if (irq[c]) irq_n[c]++;
                if (dack[c]) run[c]++;
                else begin
                    if (run[c] > max_run) max_run = run[c];
                    run[c] = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input int ch, input logic [31:0] src, input logic [31:0] dst,
                        input logic [15:0] cnt, input logic [31:0] link, input logic [3:0] mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_src = src; cfg_dst = dst;
        cfg_cnt = cnt; cfg_link = link; cfg_mode = mode;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq(input int ch, input int base);
        int t = 0;
        while (irq_n[ch] == base && t < 300) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk("R9 irq count", 32'(irq_n[ch]), 32'(base + 1));
    endtask

    task automatic t_reset;
        @(negedge clk);
        // R11
        chk("R11 mem_req after reset", {31'b0, mem_req}, 32'h0);
        chk("R11 dack after reset", {28'b0, dack}, 32'h0);
        chk("R11 irq after reset", {28'b0, irq}, 32'h0);
    endtask

    task automatic t_fly_write;
        int a0, b0;
        mem[0] = 32'h0; mem[1] = 32'hFFFF_FFFF;
        per_wdata = 32'hA1B2_C3D4;
        // fly-by write, word units (mode 1011), zero-count channel 3 (mode 1011)
        load(0, 32'h0, 32'h00, 16'd6, 32'h0, 4'b1011);
        load(3, 32'h0, 32'h10, 16'd0, 32'h0, 4'b1011);
        a0 = acc_n;
        dreq[3] = 1'b1;
        repeat (10) @(negedge clk);
        // R4 / R1: no dreq on ch0, zero count on ch3
        chk("R4 no access without dreq", 32'(acc_n), 32'(a0));
        dreq[3] = 1'b0;
        b0 = irq_n[0]; log_n = 0;
        dreq[0] = 1'b1;
        wait_irq(0, b0);
        dreq[0] = 1'b0;
        // R3 R7
        chk("R3 fly write word", mem[0], 32'hA1B2_C3D4);
        chk("R7 partial fly word", mem[1], 32'hFFFF_C3D4);
        chk("R3 fly units acked", 32'(log_n), 32'd2);
        chk("R3 accesses", 32'(acc_n - a0), 32'd2);
    endtask

    task automatic t_fly_read;
        int b0;
        mem[8] = 32'h1122_3344;
        log_n = 0; b0 = irq_n[1];
        // fly-by read of one byte (mode 0001)
        load(1, 32'h21, 32'h0, 16'd1, 32'h0, 4'b0001);
        dreq[1] = 1'b1;
        wait_irq(1, b0);
        dreq[1] = 1'b0;
        // R3
        chk("R3 fly read data to peripheral", last_prd, 32'h1122_3344);
        chk("R3 fly read address", last_addr, 32'h21);
        chk("R3 fly read ack channel", 32'(log_ch[0]), 32'd1);
    endtask

    task automatic t_pack;
        int a0, b0;
        mem[16] = 32'h4433_2211; mem[17] = 32'h8877_6655;
        mem[32] = 32'h0; mem[33] = 32'hFFFF_FFFF;
        a0 = acc_n; b0 = irq_n[2]; log_n = 0;
        // byte source, word destination (mode 1000)
        load(2, 32'h41, 32'h80, 16'd7, 32'h0, 4'b1000);
        dreq[2] = 1'b1;
        wait_irq(2, b0);
        dreq[2] = 1'b0;
        // R5 R7
        chk("R5 assembled word", mem[32], 32'h5544_3322);
        chk("R7 partial assembled word", mem[33], 32'hFF88_7766);
        chk("R5 accesses", 32'(acc_n - a0), 32'd9);
        chk("R5 units acked", 32'(log_n), 32'd2);
    endtask

    task automatic t_unpack;
        int a0, b0;
        mem[36] = 32'hDEAD_BEEF; mem[48] = 32'h0; mem[49] = 32'h0;
        a0 = acc_n; b0 = irq_n[3];
        // word source, byte destination (mode 0100)
        load(3, 32'h90, 32'hC1, 16'd4, 32'h0, 4'b0100);
        dreq[3] = 1'b1;
        wait_irq(3, b0);
        dreq[3] = 1'b0;
        // R6
        chk("R6 split bytes low word", mem[48], 32'hADBE_EF00);
        chk("R6 split byte high word", mem[49], 32'h0000_00DE);
        chk("R6 accesses", 32'(acc_n - a0), 32'd5);
    endtask

    task automatic t_chain;
        int a0, b0;
        mem[40] = 32'h0101_0101; mem[41] = 32'h0202_0202;
        mem[52] = 32'h0BAD_F00D; mem[54] = 32'h0;
        mem[56] = 32'hD0; mem[57] = 32'hD8; mem[58] = 32'd4; mem[59] = 32'h0;
        a0 = acc_n; b0 = irq_n[0]; log_n = 0;
        // word to word two-cycle (mode 1100) with link to 0xE0
        load(0, 32'hA0, 32'hB0, 16'd8, 32'hE0, 4'b1100);
        dreq[0] = 1'b1;
        wait_irq(0, b0);
        dreq[0] = 1'b0;
        // R8
        chk("R8 first descriptor word 0", mem[44], 32'h0101_0101);
        chk("R8 first descriptor word 1", mem[45], 32'h0202_0202);
        chk("R8 chained descriptor copy", mem[54], 32'h0BAD_F00D);
        chk("R8 accesses incl fetch", 32'(acc_n - a0), 32'd10);
        chk("R8 acks exclude fetch", 32'(log_n), 32'd3);
    endtask

    task automatic t_priority;
        int b1, b3;
        per_wdata = 32'h5A5A_5A5A;
        b1 = irq_n[1]; b3 = irq_n[3];
        load(1, 32'h0, 32'h00, 16'd8, 32'h0, 4'b1011);
        load(3, 32'h0, 32'h10, 16'd4, 32'h0, 4'b1011);
        log_n = 0;
        dreq[1] = 1'b1; dreq[3] = 1'b1;
        wait_irq(1, b1);
        repeat (5) @(negedge clk);
        dreq = '0;
        // R2
        chk("R2 first unit channel", 32'(log_ch[0]), 32'd1);
        chk("R2 second unit channel", 32'(log_ch[1]), 32'd3);
        chk("R2 third unit channel", 32'(log_ch[2]), 32'd1);
        chk("R2 ch3 done", 32'(irq_n[3]), 32'(b3 + 1));
        chk("R3 fly data written", mem[4], 32'h5A5A_5A5A);
    endtask

    task automatic t_stall;
        int a0, b0;
        mem[24] = 32'h0;
        per_wdata = 32'hCAFE_0001;
        mem_gnt = 1'b0;
        a0 = acc_n; b0 = irq_n[2];
        load(2, 32'h0, 32'h60, 16'd4, 32'h0, 4'b1011);
        dreq[2] = 1'b1;
        repeat (6) @(negedge clk);
        // R10
        chk("R10 request held", {31'b0, mem_req}, 32'h1);
        chk("R10 address held", mem_addr, 32'h60);
        chk("R10 no ack while stalled", {28'b0, dack}, 32'h0);
        chk("R10 nothing completed", 32'(acc_n), 32'(a0));
        mem_gnt = 1'b1;
        wait_irq(2, b0);
        dreq[2] = 1'b0;
        chk("R10 write after grant", mem[24], 32'hCAFE_0001);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) begin irq_n[i] = 0; run[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fly_write();
        t_fly_read();
        t_pack();
        t_unpack();
        t_chain();
        t_priority();
        t_stall();
        repeat (4) @(negedge clk);
        // R4
        chk("R4 dack length", 32'(max_run), 32'd2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule